// File: doc/BRIEF.md
# Snapshot Timestamp Counter

A 64-bit counter runs from reset, advancing by one on every clock edge and rolling over to zero after its largest value. Software never reads the live counter. It reads two 32-bit snapshot words instead: a low word and a high word. These words change only when software asks for a capture, asks for a wipe, or loads them directly through a 32-bit register port.

A control register accepts two one-shot command bits. The capture bit copies the live count into both snapshot words. The wipe bit sets both words to zero. Neither command bit is stored. All other control bits are kept exactly as written. Reads are combinational: a read returns the addressed register in the same cycle, and any address that is not mapped reads as zero.

Top module: `stamp_counter`

## Requirements
- R1: After reset, the control register at offset 0xA0, the low snapshot at 0xA4 and the high snapshot at 0xA8 all read 0.
- R2: A control write with bit 1 (capture) set and bit 0 clear loads the count held in the write cycle into the snapshots: bits [31:0] go to the low word and bits [63:32] go to the high word.
- R3: The live count goes up by exactly one per clock cycle after reset and wraps modulo 2^64. Two captures taken N cycles apart therefore differ by N.
- R4: Command bits 0 and 1 always read back as 0 from the control register.
- R5: A control write with bit 0 (wipe) set, and bit 1 clear, zeroes both snapshot words.
- R6: A control write with bits 1 and 0 both set performs the capture first and the wipe second. Both snapshots end at 0.
- R7: Writes to 0xA4 and 0xA8 load the low and high words independently. The snapshots hold their values while there are no writes.
- R8: Control bits [31:2] read back as last written. A control write with bits 1 and 0 both clear leaves the snapshots unchanged.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 12 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |

## Verification
The capture and the wipe can be requested by the same control write. They then fall in the same cycle. The bench first loads a nonzero value into a snapshot word. It then writes the control register with both command bits set, which also drives all upper control bits high. It expects both snapshot words at zero and the control register at all ones with the two low bits clear. The other same-cycle pairing is a capture against the counter advancing on that edge. It is judged by requiring the captured value to equal the bench's cycle count from before the edge, across a sweep of capture spacings.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int SEL_W = 4;
  localparam int WIPE_BIT = 0;
  localparam int SNAP_BIT = 1;

  typedef struct packed {
    logic             snap;
    logic             wipe;
    logic             load;
    logic [SEL_W-1:0] loadIdx;
  } snap_cmd_t;
endpackage

// File: rtl/stamp_free_count.sv
module stamp_free_count #(
  parameter int COUNT_W = 64,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [COUNT_W-1:0] countNow
);
  localparam int NUM_SEG = COUNT_W / REG_W;

  logic [NUM_SEG-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [REG_W-1:0] segVal;
    always_ff @(posedge clk) begin
      if (rst)           segVal <= '0;
      else if (carry[g]) segVal <= segVal + REG_W'(1);
    end
    assign countNow[g*REG_W +: REG_W] = segVal;
    if (g + 1 < NUM_SEG) begin : g_chain
      assign carry[g+1] = carry[g] & (&segVal);
    end
  end
endmodule

// File: rtl/stamp_snap_regs.sv
module stamp_snap_regs
  import stamp_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  snap_cmd_t          cmd,
  input  logic [REG_W-1:0]   wrData,
  input  logic [COUNT_W-1:0] countNow,
  output logic [COUNT_W-1:0] snapFlat
);
  localparam int NUM_SEG = COUNT_W / REG_W;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_word
    logic [REG_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst)           word <= '0;
      else if (cmd.wipe) word <= '0;
      else if (cmd.snap) word <= countNow[g*REG_W +: REG_W];
      else if (cmd.load && cmd.loadIdx == SEL_W'(g)) word <= wrData;
    end
    assign snapFlat[g*REG_W +: REG_W] = word;
  end
endmodule

// File: rtl/stamp_reg_ctrl.sv
module stamp_reg_ctrl
  import stamp_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 12,
  parameter int CTRL_OFS = 'hA0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [COUNT_W-1:0] snapFlat,
  output snap_cmd_t          cmd,
  output logic [REG_W-1:0]   rdData
);
  localparam int NUM_SEG = COUNT_W / REG_W;
  localparam logic [REG_W-1:0] CMD_MASK =
    (REG_W'(1) << WIPE_BIT) | (REG_W'(1) << SNAP_BIT);

  logic [REG_W-1:0]   ctrlStore;
  logic               hitCtrl;
  logic [NUM_SEG-1:0] hitWord;

  assign hitCtrl = (addr == ADDR_W'(CTRL_OFS));
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
    assign hitWord[g] = (addr == ADDR_W'(CTRL_OFS + 4 * (g + 1)));
  end

  always_comb begin
    cmd = '0;
    if (wrEn && hitCtrl) begin
      cmd.snap = wrData[SNAP_BIT];
      cmd.wipe = wrData[WIPE_BIT];
    end
    for (int k = 0; k < NUM_SEG; k++) begin
      if (wrEn && hitWord[k]) begin
        cmd.load    = 1'b1;
        cmd.loadIdx = SEL_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  ctrlStore <= '0;
    else if (wrEn && hitCtrl) ctrlStore <= wrData & ~CMD_MASK;
  end

  always_comb begin
    rdData = '0;
    if (hitCtrl) rdData = ctrlStore;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (hitWord[k]) rdData = snapFlat[k*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter
  import stamp_pkg::*;
#(
  parameter int COUNT_W  = 64,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 12,
  parameter int CTRL_OFS = 'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData
);
  snap_cmd_t          cmd;
  logic [COUNT_W-1:0] countNow;
  logic [COUNT_W-1:0] snapFlat;

  stamp_free_count #(.COUNT_W(COUNT_W), .REG_W(REG_W)) u_count (
    .clk(clk), .rst(rst), .countNow(countNow)
  );

  stamp_snap_regs #(.COUNT_W(COUNT_W), .REG_W(REG_W)) u_snap (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wrData),
    .countNow(countNow), .snapFlat(snapFlat)
  );

  stamp_reg_ctrl #(.COUNT_W(COUNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
                   .CTRL_OFS(CTRL_OFS)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .snapFlat(snapFlat), .cmd(cmd), .rdData(rdData)
  );
endmodule

// File: rtl/stamp_counter_chk.sv
module stamp_counter_chk #(
  parameter int COUNT_W  = 64,
  parameter int ADDR_W   = 12,
  parameter int CTRL_OFS = 'hA0
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [1:0]         wrCmd,
  input logic [1:0]         rdLow,
  input logic [COUNT_W-1:0] countNow,
  input logic [COUNT_W-1:0] snapFlat
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (addr == ADDR_W'(CTRL_OFS));

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (snapFlat == '0));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (countNow == $past(countNow) + COUNT_W'(1)));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && wrCmd == 2'b10) |=> (snapFlat == $past(countNow)));

  p_wipe_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && wrCmd[0]) |=> (snapFlat == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(snapFlat));

  p_cmd_bits_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(CTRL_OFS)) |-> (rdLow == 2'b00));
endmodule

bind stamp_counter stamp_counter_chk #(
  .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrCmd(wrData[1:0]),
  .rdLow(rdData[1:0]), .countNow(countNow), .snapFlat(snapFlat)
);

// File: tb/stamp_counter_test.sv
module stamp_counter_test;
  localparam logic [11:0] A_CTRL = 12'hA0;
  localparam logic [11:0] A_LO   = 12'hA4;
  localparam logic [11:0] A_HI   = 12'hA8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] refCount = '0;

  stamp_counter uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) refCount <= '0;
    else     refCount <= refCount + 64'd1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic capture(output logic [63:0] expVal);
    @(negedge clk);
    addr = A_CTRL; wrData = 32'h2; wrEn = 1'b1;
    expVal = refCount;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lo;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [31:0] prevLo;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_CTRL, d); check("R1 ctrl", 64'(d), 64'd0);
    rd(A_LO, d);   check("R1 lo", 64'(d), 64'd0);
    rd(A_HI, d);   check("R1 hi", 64'(d), 64'd0);

    // R2 / R3: captures at swept spacings
    capture(e1);
    rd(A_LO, lo); check("R2 lo capture", 64'(lo), 64'(e1[31:0]));
    rd(A_HI, d);  check("R2 hi capture", 64'(d), 64'(e1[63:32]));
    prevLo = lo;
    for (int gap = 0; gap < 24; gap++) begin
      repeat (gap) @(negedge clk);
      capture(e2);
      rd(A_LO, lo);
      check("R2 lo sweep", 64'(lo), 64'(e2[31:0]));
      check("R3 step", 64'(lo - prevLo), e2 - e1);
      prevLo = lo; e1 = e2;
    end

    // R4 / R8: control readback with upper bits swept
    for (int b = 2; b < 32; b++) begin
      wr(A_CTRL, (32'h1 << b) | 32'h0);
      rd(A_CTRL, d);
      check("R8 ctrl bit", 64'(d), 64'(32'h1 << b));
    end

    // R7: direct loads, independent words
    wr(A_LO, 32'hA5A5_1234);
    wr(A_HI, 32'h0F0F_CAFE);
    rd(A_LO, d); check("R7 lo load", 64'(d), 64'h0000_0000_A5A5_1234);
    rd(A_HI, d); check("R7 hi load", 64'(d), 64'h0000_0000_0F0F_CAFE);
    repeat (10) @(negedge clk);
    rd(A_LO, d); check("R7 lo hold", 64'(d), 64'h0000_0000_A5A5_1234);

    // R8: control write with no command bits keeps snapshots
    wr(A_CTRL, 32'h0000_0100);
    rd(A_LO, d); check("R8 lo untouched", 64'(d), 64'h0000_0000_A5A5_1234);
    rd(A_HI, d); check("R8 hi untouched", 64'(d), 64'h0000_0000_0F0F_CAFE);

    // R9: unmapped reads and writes
    for (int a = 0; a < 256; a += 4) begin
      if (a != 'hA0 && a != 'hA4 && a != 'hA8) begin
        rd(12'(a), d); check("R9 unmapped read", 64'(d), 64'd0);
      end
    end
    wr(12'h09C, 32'hFFFF_FFFF);
    wr(12'h0AC, 32'hFFFF_FFFF);
    wr(12'h1A4, 32'hFFFF_FFFF);
    rd(A_LO, d);   check("R9 lo after stray", 64'(d), 64'h0000_0000_A5A5_1234);
    rd(A_HI, d);   check("R9 hi after stray", 64'(d), 64'h0000_0000_0F0F_CAFE);
    rd(A_CTRL, d); check("R9 ctrl after stray", 64'(d), 64'h0000_0000_0000_0100);

    // R5: wipe alone
    wr(A_CTRL, 32'h0000_0001);
    rd(A_LO, d);   check("R5 lo wiped", 64'(d), 64'd0);
    rd(A_HI, d);   check("R5 hi wiped", 64'(d), 64'd0);
    rd(A_CTRL, d); check("R4 wipe bit reads 0", 64'(d), 64'd0);

    // R6: capture and wipe together, upper bits all set
    wr(A_LO, 32'h1357_9BDF);
    wr(A_HI, 32'h2468_ACE0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_LO, d);   check("R6 lo zero", 64'(d), 64'd0);
    rd(A_HI, d);   check("R6 hi zero", 64'(d), 64'd0);
    rd(A_CTRL, d); check("R4 command bits 0", 64'(d), 64'h0000_0000_FFFF_FFFC);

    // R2 after wipe: capture works again
    capture(e1);
    rd(A_LO, d);   check("R2 recapture", 64'(d), 64'(e1[31:0]));
    rd(A_CTRL, d); check("R4 capture bit reads 0", 64'(d), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule